// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is an 8-bit down counter for a real-time-clock subsystem. A prescaler outside the block supplies four one-cycle enable strobes at 4096 Hz, 64 Hz, 1 Hz and one per minute. A two-bit select field in the timer control register picks one of them, and an enable bit in the same register gates it. Each selected strobe moves the counter one step down. When a strobe arrives with the count at 1, the block sets a sticky timer flag and loads the counter again from the last value the host wrote.

The host reaches the block through a plain register port. Writes are accepted in every cycle and are never back-pressured, so the port has no ready signal. Reads are combinational on the read address. The status register holds the timer flag, an alarm flag that a one-cycle alarm event input sets, and the timer interrupt enable. A write to the status register clears flags by AND-masking them with the written data, so a zero written to one flag position leaves the other flag untouched. The interrupt output follows the timer flag while the interrupt enable is set.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count reads 00h, the control register reads 00h, the status register reads 00h and `irq` is low.
- R2: Control bits [1:0] select the tick source: 0 selects `src_tick[0]` (4096 Hz), 1 selects `src_tick[1]` (64 Hz), 2 selects `src_tick[2]` (1 Hz) and 3 selects `src_tick[3]` (one per minute). Strobes on the sources that are not selected leave the count unchanged.
- R3: Control bit 7 enables the timer. While it is 0 the count holds, even when the selected strobe is present.
- R4: A selected strobe with the count at 1 sets the timer flag (status bit 2) and loads the count with the last value written to address 0Fh. A strobe with the count above 1 decrements it by one.
- R5: The timer flag stays set until a status write (address 01h) carries 0 in bit 2.
- R6: With a count of 0 the timer is idle. Strobes leave the count at 0 and set no flag.
- R7: A write to address 0Fh sets both the count and the reload value. The new count is readable one cycle after the write, and the next selected strobe decrements from it. A count write in the same cycle as a strobe takes precedence over that strobe.
- R8: A status write stores bit 0 as the interrupt enable and ANDs bit 2 into the timer flag and bit 3 into the alarm flag. Writing 1 to a flag position keeps that flag. The `alarm_evt` input sets the alarm flag (status bit 3).
- R9: `irq` is high exactly when both the timer flag and the interrupt enable are set.
- R10: When a flag is set in the same cycle as a status write that would clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Prescaler strobes: [0] 4096 Hz, [1] 64 Hz, [2] 1 Hz, [3] per minute |
| alarm_evt | input | 1 | One-cycle pulse that sets the alarm flag |
| wr_en | input | 1 | Host write strobe, accepted every cycle |
| wr_addr | input | 4 | Write address: 01h status, 0Eh control, 0Fh count |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Register read data, combinational on rd_addr |
| irq | output | 1 | Timer interrupt request |

## Verification
Every write and every selected strobe takes effect at the clock edge where it is sampled. Its result can be read on `rd_data` and `irq` from that edge until the next one, so each result is due one cycle after its stimulus. The driver applies each stimulus at a falling edge and queues the expected register values right after the following rising edge. The monitor pops the queue at the next falling edge and compares. Because of this, every comparison falls halfway through the cycle in which the result is due, and never at an edge.

// File: rtl/cdt_pkg.sv
`timescale 1ns/1ps
package cdt_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_STAT = 4'h1;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'hE;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'hF;

  localparam int unsigned B_TIE = 0;
  localparam int unsigned B_TF  = 2;
  localparam int unsigned B_AF  = 3;
  localparam int unsigned B_EN  = 7;

  typedef struct packed {
    logic tie;
    logic tf;
    logic af;
  } flags_t;
endpackage

// File: rtl/cdt_src_mux.sv
`timescale 1ns/1ps
module cdt_src_mux #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic             tick
);
  logic [N_SRC-1:0] hit;
  for (genvar i = 0; i < N_SRC; i++) begin : g_dec
    assign hit[i] = src_tick[i] && (sel == SEL_W'(i));
  end
  assign tick = en && (|hit);
endmodule

// File: rtl/cdt_counter.sv
`timescale 1ns/1ps
module cdt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic [W-1:0] reload,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = W'(1);

  assign wrap = tick && !load && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
    end else if (load) begin
      cnt    <= load_val;
      reload <= load_val;
    end else if (tick && cnt != '0) begin
      cnt <= (cnt == ONE) ? reload : cnt - ONE;
    end
  end
endmodule

// File: rtl/cdt_flags.sv
`timescale 1ns/1ps
module cdt_flags
  import cdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tf_set,
  input  logic             af_set,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output flags_t           flags
);
  flags_t nxt;

  always_comb begin
    nxt = flags;
    if (wr) begin
      nxt.tie = wdata[B_TIE];
      nxt.tf  = flags.tf && wdata[B_TF];
      nxt.af  = flags.af && wdata[B_AF];
    end
    if (tf_set) nxt.tf = 1'b1;
    if (af_set) nxt.af = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end
endmodule

// File: rtl/cdt_timer.sv
`timescale 1ns/1ps
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_tick,
  input  logic              alarm_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_tick;
  logic             cnt_wr, stat_wr, wrap;
  logic [CNT_W-1:0] cnt, reload;
  flags_t           flags;

  assign cnt_wr  = wr_en && (wr_addr == A_CNT);
  assign stat_wr = wr_en && (wr_addr == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (wr_en && wr_addr == A_CTRL) begin
      en_q  <= wr_data[B_EN];
      sel_q <= wr_data[SEL_W-1:0];
    end
  end

  cdt_src_mux #(.N_SRC(N_SRC)) u_mux (
    .src_tick(src_tick), .sel(sel_q), .en(en_q), .tick(sel_tick)
  );

  cdt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(sel_tick), .load(cnt_wr),
    .load_val(wr_data[CNT_W-1:0]), .cnt(cnt), .reload(reload), .wrap(wrap)
  );

  cdt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .tf_set(wrap), .af_set(alarm_evt),
    .wr(stat_wr), .wdata(wr_data), .flags(flags)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_STAT: begin
        rd_data[B_TIE] = flags.tie;
        rd_data[B_TF]  = flags.tf;
        rd_data[B_AF]  = flags.af;
      end
      A_CTRL: begin
        rd_data[B_EN]        = en_q;
        rd_data[SEL_W-1:0]   = sel_q;
      end
      A_CNT:   rd_data[CNT_W-1:0] = cnt;
      default: rd_data = '0;
    endcase
  end

  assign irq = flags.tf && flags.tie;
endmodule

// File: rtl/cdt_checker.sv
`timescale 1ns/1ps
module cdt_checker
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic              alarm_evt,
  input logic              sel_tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input flags_t            flags,
  input logic              irq
);
  logic cw, sw;
  assign cw = wr_en && wr_addr == A_CNT;
  assign sw = wr_en && wr_addr == A_STAT;

  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tick && !cw && cnt == CNT_W'(1) |=> cnt == $past(reload) && flags.tf);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick && !cw |=> $stable(cnt));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == '0 && !cw |=> cnt == '0);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags.tf && !sw |=> flags.tf);

  p_keep_af_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flags.af && sw && wr_data[B_AF] |=> flags.af);

  p_af_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flags.af);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> flags.tie);
endmodule

bind cdt_timer cdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .alarm_evt(alarm_evt), .sel_tick(sel_tick),
  .cnt(cnt), .reload(reload), .flags(flags), .irq(irq)
);

// File: tb/cdt_timer_tb.sv
`timescale 1ns/1ps
module cdt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic       alarm_evt = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] q_addr[$];
  bit         q_irq[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  cdt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .alarm_evt(alarm_evt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                     input logic [3:0] t, input logic al);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; src_tick = t; alarm_evt = al;
    @(posedge clk);
    #0.5;
    wr_en = 1'b0; src_tick = '0; alarm_evt = 1'b0;
  endtask

  task automatic exp_reg(input logic [3:0] a, input logic [7:0] v, input string tag);
    q_addr.push_back(a); q_irq.push_back(1'b0); q_exp.push_back(v); q_tag.push_back(tag);
  endtask

  task automatic exp_irq(input logic v, input string tag);
    q_addr.push_back(4'h0); q_irq.push_back(1'b1); q_exp.push_back({7'd0, v}); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (q_addr.size() > 0) begin
      logic [3:0] a;
      bit         k;
      logic [7:0] e;
      string      t;
      logic [7:0] act;
      a = q_addr.pop_front(); k = q_irq.pop_front();
      e = q_exp.pop_front();  t = q_tag.pop_front();
      rd_addr = a;
      #0.1;
      act = k ? {7'd0, irq} : rd_data;
      checks++;
      if (act !== e) begin
        fails++;
        $display("FAIL %s addr %0h: actual %02h expected %02h", t, a, act, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    exp_reg(4'hF, 8'h00, "R1"); exp_reg(4'hE, 8'h00, "R1");
    exp_reg(4'h1, 8'h00, "R1"); exp_irq(1'b0, "R1");
    cyc(1, 4'hE, 8'h80, 4'h0, 0);
    cyc(1, 4'hF, 8'h03, 4'h0, 0);
    exp_reg(4'hF, 8'h03, "R7");
    cyc(0, 4'h0, 8'h00, 4'b0010, 0); exp_reg(4'hF, 8'h03, "R2 unselected");
    cyc(0, 4'h0, 8'h00, 4'b0001, 0); exp_reg(4'hF, 8'h02, "R2 sel0");
    cyc(0, 4'h0, 8'h00, 4'b0001, 0); exp_reg(4'hF, 8'h01, "R4 decrement");
    cyc(0, 4'h0, 8'h00, 4'b0001, 0);
    exp_reg(4'hF, 8'h03, "R4 reload"); exp_reg(4'h1, 8'h04, "R4 flag");
    exp_irq(1'b0, "R9 tie off");
    cyc(1, 4'h1, 8'h05, 4'h0, 0);
    exp_reg(4'h1, 8'h05, "R8 keep tf"); exp_irq(1'b1, "R9 on");
    cyc(0, 4'h0, 8'h00, 4'h0, 0); cyc(0, 4'h0, 8'h00, 4'h0, 0);
    exp_reg(4'h1, 8'h05, "R5 sticky");
    cyc(0, 4'h0, 8'h00, 4'h0, 1); exp_reg(4'h1, 8'h0D, "R8 alarm set");
    cyc(1, 4'h1, 8'h09, 4'h0, 0);
    exp_reg(4'h1, 8'h09, "R8 clear tf keep af"); exp_irq(1'b0, "R9 tf clear");
    cyc(1, 4'hE, 8'h01, 4'h0, 0); exp_reg(4'hE, 8'h01, "R3 ctrl");
    cyc(0, 4'h0, 8'h00, 4'b0010, 0); exp_reg(4'hF, 8'h03, "R3 disabled");
    cyc(1, 4'hE, 8'h81, 4'h0, 0);
    cyc(0, 4'h0, 8'h00, 4'b0001, 0); exp_reg(4'hF, 8'h03, "R2 sel1 ignores src0");
    cyc(0, 4'h0, 8'h00, 4'b0010, 0); exp_reg(4'hF, 8'h02, "R2 sel1");
    cyc(1, 4'hE, 8'h82, 4'h0, 0);
    cyc(0, 4'h0, 8'h00, 4'b0010, 0); exp_reg(4'hF, 8'h02, "R2 sel2 ignores src1");
    cyc(0, 4'h0, 8'h00, 4'b0100, 0); exp_reg(4'hF, 8'h01, "R2 sel2");
    cyc(1, 4'hE, 8'h83, 4'h0, 0);
    cyc(1, 4'h1, 8'h01, 4'b1000, 0);
    exp_reg(4'hF, 8'h03, "R2 sel3 reload"); exp_reg(4'h1, 8'h05, "R10 set wins");
    cyc(1, 4'hF, 8'h05, 4'b1000, 0); exp_reg(4'hF, 8'h05, "R7 write wins");
    cyc(0, 4'h0, 8'h00, 4'b1000, 0); exp_reg(4'hF, 8'h04, "R7 next tick");
    cyc(1, 4'h1, 8'h01, 4'h0, 0);
    cyc(1, 4'hF, 8'h00, 4'h0, 0);
    cyc(0, 4'h0, 8'h00, 4'b1000, 0); cyc(0, 4'h0, 8'h00, 4'b1000, 0);
    exp_reg(4'hF, 8'h00, "R6 idle count"); exp_reg(4'h1, 8'h01, "R6 no flag");
    cyc(1, 4'hF, 8'h01, 4'h0, 0);
    cyc(0, 4'h0, 8'h00, 4'b1000, 0);
    exp_reg(4'hF, 8'h01, "R4 reload one"); exp_reg(4'h1, 8'h05, "R4 flag one");
    repeat (3) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule